// File: doc/BRIEF.md
# External Chip Select Generator

This block turns a small controller's 16-bit internal address bus and its read/write requests into active-low pins for external memory: a general-purpose select for one fixed 16 KB window, a program-memory select driven by the top address bit, and separate read and write strobes. Each select has its own enable bit. All four pins come from registers on the bus clock, so they change one cycle after the request is seen.

Each cycle an access flag marks whether the request targets on-chip resources or the external bus. In normal operation the pins stay quiet during on-chip accesses. This avoids spurious activity on the external bus. A debug visibility bit lets on-chip accesses show on the pins, so a logic analyser can follow all bus traffic.

Top module: `ext_cs_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `gp_cs_n`, `pgm_cs_n`, `rd_n` and `wr_n` are all 1.
- R2: For a visible access with `gp_en`=1, `gp_cs_n` goes to 0 exactly when the address lies in 0x4000..0x7FFF inclusive. Addresses 0x3FFF and 0x8000 leave it at 1.
- R3: For a visible access with `pgm_en`=1, `pgm_cs_n` equals address bit 15. It is 0 for 0x0000..0x7FFF and 1 for 0x8000..0xFFFF.
- R4: A select whose enable bit (`gp_en` or `pgm_en`) is 0 stays 1 whatever the address and access type.
- R5: With `vis_mode`=0, an access with `int_acc`=1 leaves all four outputs at 1.
- R6: With `vis_mode`=1, an access with `int_acc`=1 drives the strobes and the enabled, in-range selects exactly as an external access would.
- R7: At most one strobe is 0 in any cycle. A read drives `rd_n` to 0. A write drives `wr_n` to 0. If both requests are high, the write wins and `rd_n` stays 1. A cycle with neither request leaves all four outputs at 1.
- R8: Outputs reflect the inputs sampled at the previous rising clock edge, and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Internal address bus |
| rd_req | input | 1 | Read request this cycle |
| wr_req | input | 1 | Write request this cycle |
| int_acc | input | 1 | 1 = access targets an on-chip resource |
| gp_en | input | 1 | Enable for the general-purpose select |
| pgm_en | input | 1 | Enable for the program-memory select |
| vis_mode | input | 1 | 1 = on-chip accesses are shown on the pins |
| gp_cs_n | output | 1 | General-purpose select, active low |
| pgm_cs_n | output | 1 | Program-memory select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench probes both window edges (0x3FFF, 0x4000, 0x7FFF, 0x8000). An off-by-one decode would show up there as a select that is missing or lingers. It repeats accesses on-chip with visibility off and on. A design that ignored the access flag would toggle pins during on-chip traffic. One that ignored visibility mode would hide on-chip traffic while debugging. It also issues simultaneous read and write requests, idle cycles and disabled selects, where a faulty design would drive both strobes, a stray select, or a select its enable bit should have blocked. Finally, it checks the pins just after new inputs are applied, which exposes a design that passes inputs straight through without the register.

// File: rtl/ext_cs_gen.sv
module ext_cs_gen #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] GP_LO = 16'h4000,
  parameter logic [ADDR_W-1:0] GP_HI = 16'h7FFF,
  parameter int PGM_BIT = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              int_acc,
  input  logic              gp_en,
  input  logic              pgm_en,
  input  logic              vis_mode,
  output logic              gp_cs_n,
  output logic              pgm_cs_n,
  output logic              rd_n,
  output logic              wr_n
);

  logic shown, in_gp, in_pgm;

  assign shown  = (rd_req | wr_req) & (~int_acc | vis_mode);
  assign in_gp  = (addr >= GP_LO) && (addr <= GP_HI);
  assign in_pgm = ~addr[PGM_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gp_cs_n  <= 1'b1;
      pgm_cs_n <= 1'b1;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
    end else begin
      gp_cs_n  <= ~(shown & gp_en & in_gp);
      pgm_cs_n <= ~(shown & pgm_en & in_pgm);
      wr_n     <= ~(shown & wr_req);
      rd_n     <= ~(shown & rd_req & ~wr_req);
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (gp_cs_n && pgm_cs_n && rd_n && wr_n));

  p_gp_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(rd_req && !int_acc && gp_en && addr >= 16'h4000 && addr <= 16'h7FFF))
      |-> !gp_cs_n);

  p_pgm_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(addr[ADDR_W-1])) |-> pgm_cs_n);

  p_gp_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(gp_en)) |-> gp_cs_n);

  p_pgm_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(pgm_en)) |-> pgm_cs_n);

  p_hidden_internal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(int_acc && !vis_mode))
      |-> (gp_cs_n && pgm_cs_n && rd_n && wr_n));

  p_visible_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(int_acc && vis_mode && wr_req)) |-> !wr_n);

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!rd_req && !wr_req))
      |-> (gp_cs_n && pgm_cs_n && rd_n && wr_n));

endmodule

// File: tb/tb_ext_cs_gen.sv
`timescale 1ns/1ps
module tb_ext_cs_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic rd_req = 0, wr_req = 0, int_acc = 0, gp_en = 0, pgm_en = 0, vis_mode = 0;
  logic gp_cs_n, pgm_cs_n, rd_n, wr_n;

  always #2.5 clk = ~clk;

  ext_cs_gen dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_req(rd_req), .wr_req(wr_req),
    .int_acc(int_acc), .gp_en(gp_en), .pgm_en(pgm_en), .vis_mode(vis_mode),
    .gp_cs_n(gp_cs_n), .pgm_cs_n(pgm_cs_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  logic [3:0] last_exp = 4'hF;
  bit done = 0;

  function automatic logic [3:0] model(logic [15:0] a, logic r, logic w, logic ia,
                                       logic ge, logic pe, logic vm);
    logic act, g, p, rs, ws;
    act = (r || w) && (!ia || vm);
    g  = act && ge && a >= 16'h4000 && a <= 16'h7FFF;
    p  = act && pe && a < 16'h8000;
    ws = act && w;
    rs = act && r && !w;
    return {!g, !p, !rs, !ws};
  endfunction

  task automatic check(logic [3:0] act, logic [3:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got {gp,pgm,rd,wr}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] a, logic r, logic w, logic ia,
                       logic ge, logic pe, logic vm, string tag);
    item_t it;
    @(negedge clk);
    addr = a; rd_req = r; wr_req = w; int_acc = ia;
    gp_en = ge; pgm_en = pe; vis_mode = vm;
    it.exp = model(a, r, w, ia, ge, pe, vm);
    it.tag = tag;
    sb.push_back(it);
    #1;
    check({gp_cs_n, pgm_cs_n, rd_n, wr_n}, last_exp, "R8 no change before edge");
    last_exp = it.exp;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({gp_cs_n, pgm_cs_n, rd_n, wr_n}, it.exp, it.tag);
      end
    end
  end

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({gp_cs_n, pgm_cs_n, rd_n, wr_n}, 4'hF, "R1 in reset");
    addr = 16'h4000; rd_req = 1; gp_en = 1; pgm_en = 1;
    @(negedge clk);
    check({gp_cs_n, pgm_cs_n, rd_n, wr_n}, 4'hF, "R1 in reset with request");
    rd_req = 0;
    rst_n = 1;
    @(posedge clk); #1;
    check({gp_cs_n, pgm_cs_n, rd_n, wr_n}, 4'hF, "R1 first cycle after reset");
    last_exp = 4'hF;

    apply(16'h4000, 1, 0, 0, 1, 1, 0, "R2 low edge read");
    apply(16'h7FFF, 1, 0, 0, 1, 1, 0, "R2 high edge read");
    apply(16'h3FFF, 1, 0, 0, 1, 1, 0, "R2 below window");
    apply(16'h8000, 0, 1, 0, 1, 1, 0, "R2 above window write");
    apply(16'h0000, 1, 0, 0, 1, 1, 0, "R3 bottom of lower half");
    apply(16'hFFFF, 1, 0, 0, 1, 1, 0, "R3 top of upper half");
    apply(16'h5000, 1, 0, 0, 0, 1, 0, "R4 gp disabled");
    apply(16'h5000, 0, 1, 0, 1, 0, 0, "R4 pgm disabled");
    apply(16'h5000, 1, 0, 0, 0, 0, 1, "R4 both disabled");
    apply(16'h4800, 1, 0, 1, 1, 1, 0, "R5 internal read hidden");
    apply(16'h1000, 0, 1, 1, 1, 1, 0, "R5 internal write hidden");
    apply(16'h4800, 1, 0, 1, 1, 1, 1, "R6 internal read visible");
    apply(16'h9000, 0, 1, 1, 1, 1, 1, "R6 internal write visible");
    apply(16'h6000, 1, 1, 0, 1, 1, 0, "R7 both requests write wins");
    apply(16'h6000, 0, 0, 0, 1, 1, 1, "R7 idle cycle");
    apply(16'h2000, 1, 0, 0, 1, 1, 0, "R8 back-to-back read");
    apply(16'h6000, 0, 1, 0, 1, 1, 0, "R8 back-to-back write");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      apply(rv[15:0], rv[16], rv[17], rv[18], rv[19], rv[20], rv[21], "R2 R3 R5 R6 R7 mixed");
    end

    apply(16'h0000, 0, 0, 0, 0, 0, 0, "R7 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule